// File: doc/BRIEF.md
# Split-Speculation Carry Select Adder

This block adds two unsigned (or two's complement) operands of even width together with a carry-in. It is purely combinational. It returns the sum and the carry out of the most significant bit. The operands are cut at the midpoint. The lower half is summed by one carry look-ahead sub-adder fed by the external carry-in. The upper half is summed twice at the same time: one copy assumes an incoming carry of 0 and the other assumes 1. When the lower half's carry settles, it picks one of the two upper candidates, so the upper half never waits for a carry to ripple through the lower half.

The final carry-out is not formed by a full two-input multiplexer. If the lower carry is 1, the carry of the assumed-1 copy is passed through. If the lower carry is 0, the result is the AND of both copies' carries. This works because the assumed-0 copy can only carry when the assumed-1 copy also carries. Each sub-adder computes every internal carry directly from bit-level generate and propagate terms rather than by rippling.

Top module: `csel_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + c_i`, taken as unsigned integers.
- R2: `carry_o` equals bit `WIDTH` (the bit just above the sum) of `a_i + b_i + c_i`.
- R3: Whenever the upper copy that assumes carry-in 0 produces a carry-out, the copy that assumes carry-in 1 produces one too. This shows at the ports: with an upper half of all ones in propagate form (`a_hi ^ b_hi` all ones), `carry_o` follows the lower carry.
- R4: The upper half of `sum_o` is `a_hi + b_hi` modulo 2^(WIDTH/2) when the lower half produces no carry, and `a_hi + b_hi + 1` modulo 2^(WIDTH/2) when it does. Here the lower carry is bit WIDTH/2 of `a_lo + b_lo + c_i`.
- R5: When the lower half carries, `carry_o` equals the carry of the assumed-1 upper copy, that is (`a_hi + b_hi + 1`) >= 2^(WIDTH/2).
- R6: When the lower half does not carry, `carry_o` equals the AND of both upper copies' carries, which is (`a_hi + b_hi`) >= 2^(WIDTH/2).
- R7: The lower half of `sum_o` equals `a_lo + b_lo + c_i` modulo 2^(WIDTH/2), including when a carry-in propagates through every lower bit.
- R8: A carry-in that propagates through every bit of both halves (`a_i ^ b_i` all ones, `c_i` = 1) gives `sum_o` = 0 and `carry_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
There are no registers in the block, so both results are due in the same cycle the operands are applied, with zero cycles of latency. The bench changes operands on the falling clock edge. It samples `sum_o` and `carry_o` 2 ns later, before the next rising edge, and compares them to a reference computed with integer arithmetic. The operand sweep covers all 8-bit pairs with both carry-in values, so every pairing of lower carry with upper-copy carries is exercised. Directed vectors name the full-propagate and selection-boundary cases.

// File: rtl/csel_pkg.sv
// Package: shared helpers for the carry select adder.
// Assumes callers pass an even total width.
package csel_pkg;

    // Width of one half of the split operand.
    function automatic int half_of(input int total);
        return total / 2;
    endfunction

endpackage

// File: rtl/csel_cla.sv
// Module: csel_cla
// Adds two WIDTH-bit values plus a carry-in. Every internal carry is built
// directly as a sum of products of generate/propagate terms (look-ahead),
// not by rippling. Assumes a small WIDTH (fan-in grows with WIDTH).
module csel_cla #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             ci_i,
    output logic [WIDTH-1:0] s_o,
    output logic             co_o
);
    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH:0]   cin_w;
    logic             chain_v;
    logic             term_v;
    logic             acc_v;

    // Bit-level generate and propagate terms.
    assign gen_w  = x_i & y_i;
    assign prop_w = x_i ^ y_i;

    // Look-ahead carries: each carry as an OR of product terms.
    always_comb begin
        cin_w[0] = ci_i;
        chain_v  = 1'b0;
        term_v   = 1'b0;
        acc_v    = 1'b0;
        for (int i = 1; i <= WIDTH; i++) begin
            chain_v = ci_i;
            for (int j = 0; j < i; j++) begin
                chain_v = chain_v & prop_w[j];
            end
            acc_v = chain_v;
            for (int j = 0; j < i; j++) begin
                term_v = gen_w[j];
                for (int k = j + 1; k < i; k++) begin
                    term_v = term_v & prop_w[k];
                end
                acc_v = acc_v | term_v;
            end
            cin_w[i] = acc_v;
        end
    end

    // Sum bits from propagate and the carry into each position.
    assign s_o  = prop_w ^ cin_w[WIDTH-1:0];
    assign co_o = cin_w[WIDTH];

    // Check of the look-ahead network against plain arithmetic.
    always_comb begin
        AST_CLA_SUM: assert ({co_o, s_o} ==
            ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, ci_i})); // R7
    end

endmodule

// File: rtl/csel_upper.sv
// Module: csel_upper
// Computes the upper half twice (carry-in 0 and carry-in 1), picks the sum
// with the lower carry, and forms the carry-out with the reduced selection
// sel ? c1 : (c0 & c1). Assumes c0 implies c1, which holds for any adder.
module csel_upper #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] s_o,
    output logic             co_o
);
    logic [WIDTH-1:0] sum_z_w;
    logic [WIDTH-1:0] sum_o_w;
    logic             co_z_w;
    logic             co_o_w;

    // Speculative copy assuming no incoming carry.
    csel_cla #(.WIDTH(WIDTH)) u_zero (
        .x_i  (x_i),
        .y_i  (y_i),
        .ci_i (1'b0),
        .s_o  (sum_z_w),
        .co_o (co_z_w)
    );

    // Speculative copy assuming an incoming carry.
    csel_cla #(.WIDTH(WIDTH)) u_one (
        .x_i  (x_i),
        .y_i  (y_i),
        .ci_i (1'b1),
        .s_o  (sum_o_w),
        .co_o (co_o_w)
    );

    // One 2:1 select per sum bit, steered by the lower carry.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pick
        assign s_o[gi] = sel_i ? sum_o_w[gi] : sum_z_w[gi];
    end

    // Reduced carry selection: pass c1, or AND both copies.
    assign co_o = sel_i ? co_o_w : (co_z_w & co_o_w);

    // Checks on the speculative copies and the selection.
    always_comb begin
        AST_COPY_ORDER: assert (!co_z_w || co_o_w); // R3
        AST_PICK_SUM: assert (s_o == (sel_i ? (x_i + y_i + 1'b1) : (x_i + y_i))); // R4
        AST_CARRY_HI: assert (!sel_i || (co_o == co_o_w)); // R5
        AST_CARRY_LO: assert (sel_i || (co_o == co_z_w)); // R6
    end

endmodule

// File: rtl/csel_adder.sv
// Module: csel_adder (top)
// Carry select adder: the lower half uses a look-ahead sub-adder on the
// external carry-in; its carry chooses between two speculative upper halves.
// Assumes WIDTH is even; the split is at WIDTH/2.
module csel_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    localparam int HALF = csel_pkg::half_of(WIDTH);

    logic [HALF-1:0] lo_sum_w;
    logic            lo_carry_w;
    logic [HALF-1:0] hi_sum_w;

    // Lower half on the real carry-in.
    csel_cla #(.WIDTH(HALF)) u_low (
        .x_i  (a_i[HALF-1:0]),
        .y_i  (b_i[HALF-1:0]),
        .ci_i (c_i),
        .s_o  (lo_sum_w),
        .co_o (lo_carry_w)
    );

    // Upper half, speculated and selected.
    csel_upper #(.WIDTH(HALF)) u_high (
        .x_i   (a_i[WIDTH-1:HALF]),
        .y_i   (b_i[WIDTH-1:HALF]),
        .sel_i (lo_carry_w),
        .s_o   (hi_sum_w),
        .co_o  (carry_o)
    );

    // Join the two halves into the full sum.
    assign sum_o = {hi_sum_w, lo_sum_w};

    // End-to-end check of sum and carry.
    always_comb begin
        AST_TOTAL_SUM: assert ({carry_o, sum_o} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i})); // R1 R2
    end

endmodule

// File: tb/tb_csel_adder.sv
`timescale 1ns/1ps
module tb_csel_adder;
    localparam int W = 8;
    localparam int H = W / 2;

    logic         clk;
    logic [W-1:0] a_s;
    logic [W-1:0] b_s;
    logic         c_s;
    logic [W-1:0] sum_s;
    logic         carry_s;

    int total;
    int bad;
    bit done;

    csel_adder #(.WIDTH(W)) dut (
        .a_i     (a_s),
        .b_i     (b_s),
        .c_i     (c_s),
        .sum_o   (sum_s),
        .carry_o (carry_s)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Apply on the falling edge, sample 2 ns later; compare to integer model.
    task automatic apply(input string req, input int a, input int b, input int c);
        int full;
        int exp_sum;
        int exp_cy;
        int lo_cy;
        int hi_exp;
        @(negedge clk);
        a_s = a[W-1:0];
        b_s = b[W-1:0];
        c_s = c[0];
        #2;
        full    = a + b + c;
        exp_sum = full % (1 << W);
        exp_cy  = full >> W;
        lo_cy   = ((a % (1 << H)) + (b % (1 << H)) + c) >> H;
        hi_exp  = ((a >> H) + (b >> H) + lo_cy) % (1 << H);
        total++;
        if (int'(sum_s) != exp_sum || int'(carry_s) != exp_cy) begin
            bad++;
            $display("FAIL %s a=%0d b=%0d c=%0d: got sum=%0d carry=%0d, expected sum=%0d carry=%0d",
                     req, a, b, c, sum_s, carry_s, exp_sum, exp_cy);
        end
        total++;
        if (int'(sum_s[W-1:H]) != hi_exp) begin
            bad++;
            $display("FAIL R4 a=%0d b=%0d c=%0d: got upper=%0d, expected upper=%0d",
                     a, b, c, sum_s[W-1:H], hi_exp);
        end
    endtask

    initial begin
        total = 0;
        bad   = 0;
        done  = 1'b0;
        a_s   = '0;
        b_s   = '0;
        c_s   = 1'b0;
        // Idle state: zero operands give zero results (R1, R2).
        apply("R1", 0, 0, 0);
        apply("R2", 255, 1, 0);
        // Full propagate through both halves (R8).
        apply("R8", 255, 0, 1);
        apply("R8", 8'hA5, 8'h5A, 1);
        // Lower half propagate with carry-in (R7).
        apply("R7", 8'h0F, 8'h00, 1);
        apply("R7", 8'h36, 8'h09, 1);
        // Upper all-propagate: carry_o follows lower carry (R3).
        apply("R3", 8'hF0, 8'h08, 0);
        apply("R3", 8'hF8, 8'h08, 0);
        // Lower carries: carry from assumed-1 copy (R5).
        apply("R5", 8'h7F, 8'h81, 0);
        apply("R5", 8'h3F, 8'h41, 0);
        // Lower does not carry: AND of both copies (R6).
        apply("R6", 8'hF1, 8'h11, 0);
        apply("R6", 8'h71, 8'h81, 0);
        // Alternating pattern without internal carries (R1).
        apply("R1", 8'h55, 8'hAA, 0);
        // Exhaustive sweep over operands and carry-in (R1, R2).
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    apply("R1/R2", a, b, c);
                end
            end
        end
        done = 1'b1;
    end

    // Watchdog and single summary line.
    initial begin
        for (int n = 0; n < 195000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule